// File: doc/BRIEF.md
# Programmable Reed-Solomon Byte Encoder

This block turns a stream of message bytes into systematic Reed-Solomon codewords over GF(2^8). A codeword begins on a byte flagged with `in_sop` and its message part ends on a byte flagged with `in_eop`. Every message byte is forwarded unchanged one cycle after it is accepted. After the last message byte, the block appends 2t parity bytes. These are the remainder of the message polynomial, multiplied by x^2t, divided by the generator polynomial.

The correction strength t and the encode enable are sampled from `cfg_t` and `cfg_enable` on the start byte of each codeword and hold for that whole codeword. Values of t from 0 to `MAX_T` are supported. Shortened codes need no extra setting: the message length is set only by where `in_eop` falls. While parity bytes are being emitted, `in_ready` is low and the upstream source must wait. When encoding is switched off, the block acts as a one-cycle pipeline stage.

Top module: `rs_enc_top`

## Requirements
- R1: Parity bytes are the coefficients of (m(x)·x^2t) mod g(x). Arithmetic is in GF(256) built on x^8+x^4+x^3+x^2+1 (0x11D). g(x) is the product of (x + α^i) for i = 0 to 2t−1, with α = 0x02. The first message byte is the highest-degree coefficient of m(x).
- R2: Each accepted input byte appears on `out_data` exactly one cycle later with `out_valid`=1 and `out_par`=0. Its `out_sop` copies `in_sop`.
- R3: With encoding on and t>0, exactly 2t bytes with `out_par`=1 follow the last message byte on consecutive cycles, highest-degree remainder coefficient first. Only the last parity byte carries `out_eop`, and the last message byte does not.
- R4: With encoding on and t=0, no parity byte is produced and `out_eop` marks the last message byte.
- R5: With `cfg_enable`=0 on the start byte, the codeword passes through unchanged with no parity, and `out_eop` follows `in_eop`.
- R6: `in_ready` is 0 from the cycle after the last message byte is accepted until the last parity byte is on the output. It is 1 at all other times outside reset.
- R7: The parity state restarts at every start byte. A codeword cut off without `in_eop` has no effect on the parity of the next codeword.
- R8: `cfg_t` and `cfg_enable` are only sampled on the start byte. Changes later in the codeword have no effect.
- R9: A `cfg_t` value above `MAX_T` is treated as `MAX_T`.
- R10: During reset and until the synchronized release, `out_valid` and `in_ready` are 0.
- R11: Message lengths from 16 to 255−2t bytes are encoded correctly, including the full 255-byte codeword at t = `MAX_T`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Encode enable, sampled on the start byte |
| cfg_t | input | TW | Correction strength t, sampled on the start byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a codeword |
| in_eop | input | 1 | Last message byte of a codeword |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First byte of an output codeword |
| out_eop | output | 1 | Last byte of an output codeword |
| out_par | output | 1 | Output byte is a parity byte |

## Verification
The bench uses the default `MAX_T` of 10, which gives a 20-byte parity register. This allows a complete 255-byte codeword with 235 message bytes and the largest generator. Because `cfg_t` is four bits wide, the values 11 to 15 can be driven, so the clamp to ten can be exercised. The expected parity comes from a log/antilog long division that runs separately inside the bench, and each output byte is checked against it.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  localparam logic [7:0] GF_RED = 8'h1D;  // low byte of 0x11D

  typedef enum logic {ST_MSG, ST_PAR} enc_st_e;

  // Shift-and-add multiply in GF(2^8)
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? GF_RED : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] gf_alpha_pow(input int n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < n; i++) r = gf_mul(r, 8'h02);
    return r;
  endfunction

endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/rs_gen_rom.sv
module rs_gen_rom #(
  parameter int MAX_T = 10,
  parameter int TW    = $clog2(MAX_T + 1),
  parameter int NPAR  = 2 * MAX_T
) (
  input  logic [TW-1:0]          t_sel,
  output logic [NPAR-1:0][7:0]   coef
);
  import rs_enc_pkg::*;

  // Generator of degree 2t, placed at the top of the register so the highest
  // parity stage is always stage NPAR-1; unused low stages get zero taps.
  function automatic logic [NPAR-1:0][7:0] gen_row(input int tv);
    logic [NPAR:0][7:0]   g;
    logic [NPAR-1:0][7:0] row;
    logic [7:0]           a;
    g    = '0;
    g[0] = 8'h01;
    for (int i = 0; i < 2 * tv; i++) begin
      a = gf_alpha_pow(i);
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], a);
      g[0] = gf_mul(g[0], a);
    end
    row = '0;
    for (int j = 0; j < 2 * tv; j++) row[NPAR - 2 * tv + j] = g[j];
    return row;
  endfunction

  logic [NPAR-1:0][7:0] tbl [0:MAX_T];

  for (genvar tt = 0; tt <= MAX_T; tt++) begin : g_row
    localparam logic [NPAR-1:0][7:0] ROW = gen_row(tt);
    assign tbl[tt] = ROW;
  end

  always_comb begin
    coef = '0;
    for (int i = 0; i <= MAX_T; i++) begin
      if (t_sel == TW'(i)) coef = tbl[i];
    end
  end
endmodule

// File: rtl/rs_parity_reg.sv
module rs_parity_reg #(
  parameter int NPAR = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic                 shift_en,
  input  logic                 clr,
  input  logic [7:0]           din,
  input  logic [NPAR-1:0][7:0] coef,
  output logic [7:0]           top_byte
);
  import rs_enc_pkg::*;

  logic [NPAR-1:0][7:0] par_q;
  logic [NPAR-1:0][7:0] par_d;
  logic [NPAR-1:0][7:0] upd_val;
  logic [NPAR-1:0][7:0] shf_val;
  logic [7:0]           fb;

  assign fb = din ^ (clr ? 8'h00 : par_q[NPAR-1]);

  for (genvar j = 0; j < NPAR; j++) begin : g_stage
    if (j == 0) begin : g_low
      assign upd_val[j] = gf_mul(fb, coef[j]);
      assign shf_val[j] = 8'h00;
    end else begin : g_mid
      assign upd_val[j] = (clr ? 8'h00 : par_q[j-1]) ^ gf_mul(fb, coef[j]);
      assign shf_val[j] = par_q[j-1];
    end
  end

  always_comb begin
    par_d = par_q;
    if (upd_en)        par_d = upd_val;
    else if (shift_en) par_d = shf_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  par_q <= '0;
    else if (upd_en || shift_en) par_q <= par_d;
  end

  assign top_byte = par_q[NPAR-1];
endmodule

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl #(
  parameter int MAX_T = 10,
  parameter int TW    = $clog2(MAX_T + 1),
  parameter int CW    = $clog2(2 * MAX_T + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          cfg_enable,
  input  logic [TW-1:0] cfg_t,
  output logic          in_ready,
  output logic          accept,
  output logic          upd_en,
  output logic          clr,
  output logic          shift_en,
  output logic          msg_eop,
  output logic          par_last,
  output logic [TW-1:0] act_t
);
  import rs_enc_pkg::*;

  enc_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] t_q, t_d, t_clamp;
  logic          en_q, en_d, act_en, code_en, cfg_ld;

  assign t_clamp = (cfg_t > TW'(MAX_T)) ? TW'(MAX_T) : cfg_t;
  assign act_t   = in_sop ? t_clamp : t_q;
  assign act_en  = in_sop ? cfg_enable : en_q;
  assign code_en = act_en && (act_t != '0);

  assign in_ready = rst_n && (st_q == ST_MSG);
  assign accept   = in_valid && in_ready;
  assign upd_en   = accept && act_en;
  assign clr      = accept && in_sop;
  assign shift_en = (st_q == ST_PAR);
  assign par_last = (cnt_q == CW'(1));
  assign msg_eop  = in_eop && !code_en;
  assign cfg_ld   = accept && in_sop;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    t_d   = t_q;
    en_d  = en_q;
    if (cfg_ld) begin
      t_d  = t_clamp;
      en_d = cfg_enable;
    end
    case (st_q)
      ST_MSG: begin
        if (accept && in_eop && code_en) begin
          st_d  = ST_PAR;
          cnt_d = CW'({act_t, 1'b0});
        end
      end
      ST_PAR: begin
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) st_d = ST_MSG;
      end
      default: st_d = ST_MSG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_MSG;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      en_q <= 1'b0;
    end else if (cfg_ld) begin
      t_q  <= t_d;
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/rs_enc_top.sv
module rs_enc_top #(
  parameter  int MAX_T = 10,
  localparam int TW    = $clog2(MAX_T + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [TW-1:0] cfg_t,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_par
);
  localparam int NPAR = 2 * MAX_T;
  localparam int CW   = $clog2(NPAR + 1);

  logic                 rst_int_n;
  logic                 accept, upd_en, clr, shift_en, msg_eop, par_last;
  logic [TW-1:0]        act_t;
  logic [NPAR-1:0][7:0] coef;
  logic [7:0]           par_top;

  logic       vld_d, sop_d, eop_d, par_d;
  logic [7:0] dat_d;

  rs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rs_enc_ctrl #(.MAX_T(MAX_T), .TW(TW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .cfg_enable (cfg_enable),
    .cfg_t      (cfg_t),
    .in_ready   (in_ready),
    .accept     (accept),
    .upd_en     (upd_en),
    .clr        (clr),
    .shift_en   (shift_en),
    .msg_eop    (msg_eop),
    .par_last   (par_last),
    .act_t      (act_t)
  );

  rs_gen_rom #(.MAX_T(MAX_T), .TW(TW), .NPAR(NPAR)) u_rom (
    .t_sel (act_t),
    .coef  (coef)
  );

  rs_parity_reg #(.NPAR(NPAR)) u_par (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd_en   (upd_en),
    .shift_en (shift_en),
    .clr      (clr),
    .din      (in_data),
    .coef     (coef),
    .top_byte (par_top)
  );

  always_comb begin
    vld_d = accept || shift_en;
    dat_d = accept ? in_data : par_top;
    sop_d = accept && in_sop;
    eop_d = accept ? msg_eop : (shift_en && par_last);
    par_d = !accept && shift_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_par   <= 1'b0;
    end else begin
      out_valid <= vld_d;
      out_sop   <= sop_d;
      out_eop   <= eop_d;
      out_par   <= par_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  out_data <= 8'h00;
    else if (vld_d)  out_data <= dat_d;
  end
endmodule

// File: rtl/rs_enc_chk.sv
module rs_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_sop,
  input logic       in_eop,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_par
);
  AST_ECHO_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !out_par && out_data == $past(in_data)
                                && out_sop == $past(in_sop))); // R2

  AST_PAR_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_par && !out_eop) |=> (out_valid && out_par)); // R3

  AST_NO_PAR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |=> !out_par); // R4

  AST_STALL_IN_PAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_par && !out_eop) |-> !in_ready); // R6

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid && in_ready && in_eop)); // R6
endmodule

bind rs_enc_top rs_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_sop    (in_sop),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_par   (out_par)
);

// File: tb/sim_rs_enc_top.sv
`timescale 1ns/1ps
module sim_rs_enc_top;
  logic       clk;
  logic       rst_n;
  logic       cfg_enable;
  logic [3:0] cfg_t;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       in_sop;
  logic       in_eop;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_sop;
  logic       out_eop;
  logic       out_par;

  rs_enc_top #(.MAX_T(10)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_t(cfg_t),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_par(out_par)
  );

  typedef struct {
    logic [7:0] d;
    bit         s;
    bit         e;
    bit         p;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  int   cyc    = 0;
  bit   done   = 0;

  int   gexp [0:510];
  int   glog [0:255];
  logic [7:0] work [0:511];
  logic [7:0] gen  [0:20];
  logic [7:0] msg  [0:255];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 150000);
      report();
    end
  end

  function automatic logic [7:0] lmul(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return 8'(gexp[glog[a] + glog[b]]);
  endfunction

  initial begin
    int v;
    v = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = v;
      gexp[i + 255] = v;
      glog[v] = i;
      v = v << 1;
      if (v > 255) v = v ^ 'h11D;
    end
    gexp[510] = gexp[0];
    glog[0] = 0;
  end

  // Monitor: pop expected items as the design emits bytes
  always @(negedge clk) begin
    exp_t x;
    if (rst_n && out_valid && !done) begin
      if (q.size() == 0) begin
        check(0, "R3 unexpected output byte", out_data, 0);
      end else begin
        x = q.pop_front();
        check(out_data == x.d, {x.tag, " data"}, out_data, x.d);
        check(out_sop == x.s, {x.tag, " sop"}, out_sop, x.s);
        check(out_eop == x.e, {x.tag, " eop"}, out_eop, x.e);
        check(out_par == x.p, {x.tag, " par flag"}, out_par, x.p);
      end
      if (out_par && !out_eop)
        check(!in_ready, "R6 ready during parity", in_ready, 0);
    end
  end

  // Driver: push expected bytes, then present the codeword
  task automatic send_cw(input int k, input int tcfg, input bit en, input int seed,
                         input bit poke, input bit cut, input string mtag, input string ptag);
    exp_t x;
    int   te;
    int   tt;
    logic [7:0] c;
    te = (tcfg > 10) ? 10 : tcfg;
    tt = 2 * te;
    for (int i = 0; i < k; i++) msg[i] = 8'((seed * 37 + i * 13 + i * i * 5) & 255);
    for (int i = 0; i < k; i++) begin
      x.d = msg[i];
      x.s = (i == 0);
      x.e = !cut && (i == k - 1) && !(en && te > 0);
      x.p = 0;
      x.tag = (i == 0) ? {mtag, " R2 first"} : {mtag, " R2"};
      q.push_back(x);
    end
    if (!cut && en && te > 0) begin
      for (int j = 0; j <= 20; j++) gen[j] = 0;
      gen[0] = 1;
      for (int r = 0; r < tt; r++) begin
        for (int j = tt; j > 0; j--) gen[j] = gen[j-1] ^ lmul(gen[j], 8'(gexp[r]));
        gen[0] = lmul(gen[0], 8'(gexp[r]));
      end
      for (int i = 0; i < k + tt; i++) work[i] = (i < k) ? msg[i] : 8'h00;
      for (int i = 0; i < k; i++) begin
        c = work[i];
        for (int j = 1; j <= tt; j++) work[i + j] = work[i + j] ^ lmul(c, gen[tt - j]);
      end
      for (int j = 0; j < tt; j++) begin
        x.d = work[k + j];
        x.s = 0;
        x.e = (j == tt - 1);
        x.p = 1;
        x.tag = {ptag, " R1 R3 parity"};
        q.push_back(x);
      end
    end
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 0;
      while (!in_ready) @(negedge clk);
      if (i == 0) begin
        cfg_t = 4'(tcfg);
        cfg_enable = en;
      end else if (poke) begin
        cfg_t = 4'((tcfg + 3 + i) & 15);
        cfg_enable = !en;
      end
      in_valid = 1;
      in_data = msg[i];
      in_sop = (i == 0);
      in_eop = !cut && (i == k - 1);
    end
    @(negedge clk);
    in_valid = 0;
    in_sop = 0;
    in_eop = 0;
  endtask

  initial begin
    rst_n = 0;
    in_valid = 0;
    in_data = 0;
    in_sop = 0;
    in_eop = 0;
    cfg_t = 0;
    cfg_enable = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 0, "R10 out_valid in reset", out_valid, 0);
    check(in_ready == 0, "R10 in_ready in reset", in_ready, 0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 0, "R10 in_ready before sync release", in_ready, 0);
    repeat (3) @(negedge clk);
    check(in_ready == 1, "R6 in_ready idle after reset", in_ready, 1);

    send_cw(20, 8, 1, 1, 0, 0, "t8", "R1");
    send_cw(16, 0, 1, 2, 0, 0, "R4 t0", "R4");
    send_cw(30, 5, 0, 3, 0, 0, "R5 bypass", "R5");
    send_cw(16, 1, 1, 4, 0, 0, "R11 k16", "R11");
    send_cw(235, 10, 1, 5, 0, 0, "R11 n255", "R11");
    send_cw(25, 4, 1, 6, 0, 1, "R7 cut", "R7");
    send_cw(18, 3, 1, 7, 0, 0, "R7 after cut", "R7");
    send_cw(22, 15, 1, 8, 0, 0, "R9 clamp", "R9");
    send_cw(24, 6, 1, 9, 1, 0, "R8 poke", "R8");
    send_cw(40, 2, 0, 10, 1, 0, "R8 R5 poke bypass", "R8");
    send_cw(17, 7, 1, 11, 0, 0, "t7", "R1");

    repeat (60) @(negedge clk);
    check(q.size() == 0, "R3 all expected bytes emitted", q.size(), 0);
    check(in_ready == 1, "R6 in_ready idle at end", in_ready, 1);
    done = 1;
    report();
  end
endmodule